// File: doc/BRIEF.md
# Transfer Descriptor Status Update Unit

This unit is the write-back half of a host controller's descriptor engine. It takes a descriptor control word and token together with the result of the bus transaction made for that descriptor. It returns the control word to write back to memory, the interrupt causes to post at the end of the frame, the error flags for the host status register, and a result code. The result code tells the list walker whether to advance the queue, leave it in place, abort the frame, or wait for a deferred completion. The unit also splits the token into its packet identifier, device address, endpoint number and maximum transfer length, so that the same request can drive the bus side.

Each request carries one descriptor and moves through a valid/ready handshake. With the default `OUT_REG = 1`, the response is registered: it appears one clock after acceptance and stays stable until it is taken. With `OUT_REG = 0` the unit is purely combinational between the two handshakes. The bus transaction and all memory traffic belong to the surrounding engine.

Control word bit positions: 29 short-packet detect, 28:27 retry counter, 25 isochronous, 24 interrupt-on-complete, 23 active, 22 stall, 20 babble, 19 NAK, 18 timeout, 10:0 actual length minus one. Result kinds on `res_kind`: 0 data, 1 NAK, 2 stall, 3 no device, 4 babble, 5 deferred, 6 and 7 timeout. Result codes on `rsp_code`: 0 advance, 1 hold, 2 fatal, 3 deferred. Packet identifiers: 0xE1 OUT, 0x69 IN, 0x2D SETUP.

Top module: `xfer_desc_update`

## Requirements
- R1: The token is decoded as follows: `rsp_pid` is token[7:0], `rsp_dev` is token[14:8], `rsp_ep` is token[18:15], and `rsp_maxlen` is (token[31:21] + 1) modulo 2048. An all-ones length field therefore gives a maximum of 0.
- R2: If control bit 24 is set, `rsp_imask[0]` is 1 for every outcome, including inactive descriptors and fatal results.
- R3: If control bit 23 (active) is clear, the control word is returned unchanged, the code is 1 (hold) and no error flag is raised.
- R4: An active descriptor whose PID is not 0xE1, 0x69 or 0x2D is returned unchanged, with code 2 (fatal) and `rsp_proc_err` set.
- R5: A babble result (kind 4) or a data result on an IN whose `res_count` exceeds the maximum sets bits 22 and 20 and clears bit 23. It returns code 2 and leaves bits 10:0 unchanged.
- R6: A data result writes length−1 modulo 2048 into bits 10:0, clears bits 23 and 19 and returns code 0. The length is `res_count` for IN and the maximum for OUT and SETUP.
- R7: An IN data result with bit 29 set and a count below the maximum does everything R6 does. In addition it sets `rsp_imask[1]` and returns code 1 instead of 0.
- R8: No-device and timeout results set bit 18 and return code 1. A nonzero counter in bits 28:27 is decremented. When it reaches 0, bit 23 is cleared and `rsp_usb_err` is raised. A counter of 0 stays 0 and bit 23 is kept.
- R9: A NAK result sets bit 19 and returns code 1 with bit 23 kept. On a SETUP packet the R8 handling is applied as well.
- R10: A stall result sets bit 22, clears bit 23 and returns code 1.
- R11: With bit 25 set, bit 23 is cleared before the result is applied, so NAK and retry outcomes also leave bit 23 clear.
- R12: A deferred result (kind 5) returns the control word unchanged with code 3 and no error flags.
- R13: After reset `rsp_valid` is 0 and `req_ready` is 1. A response that is not taken holds all of its fields, and `req_ready` stays low until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_ctrl | input | 32 | Descriptor control word |
| req_token | input | 32 | Descriptor token |
| res_kind | input | 3 | Bus transaction result kind |
| res_count | input | CNT_W | Bytes received on an IN |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_ctrl | output | 32 | Updated control word |
| rsp_imask | output | 2 | Interrupt causes: bit0 completion, bit1 short packet |
| rsp_code | output | 2 | Result code |
| rsp_usb_err | output | 1 | Retry counter exhausted |
| rsp_proc_err | output | 1 | Unknown packet identifier |
| rsp_pid | output | 8 | Decoded packet identifier |
| rsp_dev | output | 7 | Decoded device address |
| rsp_ep | output | 4 | Decoded endpoint |
| rsp_maxlen | output | 11 | Decoded maximum length |

## Verification
The bench targets the following corner cases:
- **Retry counter.** It is exercised at 3, 1 and 0. A decrement that wraps, or that clears the active bit at the wrong count, shows up as a wrong counter field or a spurious error flag.
- **SETUP NAK.** It must take the retry path. A design that treats it like any other NAK leaves bit 18 and the counter untouched.
- **Length edges.** An IN that overruns its maximum must become fatal babble rather than a clipped success. A zero-byte IN and a maximum-length field of all ones both check that the length−1 and maximum arithmetic wraps to 0x7FF or 0 rather than carrying into neighbouring bits.
- **Early exits.** The isochronous pre-clear, the deferred case, the inactive case and the unknown-PID case each have a design error that would disturb bits that must stay put.

// File: rtl/xdu_pkg.sv
package xdu_pkg;

   localparam int LEN_W    = 11;
   localparam int CTRL_W   = 32;

   localparam int B_SPD    = 29;
   localparam int B_ERR_LO = 27;
   localparam int B_ISO    = 25;
   localparam int B_IOC    = 24;
   localparam int B_ACT    = 23;
   localparam int B_STALL  = 22;
   localparam int B_BABBLE = 20;
   localparam int B_NAK    = 19;
   localparam int B_TMO    = 18;

   typedef enum logic [2:0] {
      RK_DATA   = 3'd0,
      RK_NAK    = 3'd1,
      RK_STALL  = 3'd2,
      RK_NODEV  = 3'd3,
      RK_BABBLE = 3'd4,
      RK_DEFER  = 3'd5,
      RK_TMO    = 3'd6,
      RK_TMO_B  = 3'd7
   } rkind_e;

   typedef enum logic [1:0] {
      OC_ADV   = 2'd0,
      OC_HOLD  = 2'd1,
      OC_FATAL = 2'd2,
      OC_DEFER = 2'd3
   } ocode_e;

   typedef struct packed {
      logic [7:0]       pid;
      logic [6:0]       dev;
      logic [3:0]       ep;
      logic [LEN_W-1:0] maxlen;
   } tok_t;

   typedef struct packed {
      logic [CTRL_W-1:0] ctrl;
      logic [1:0]        imask;
      ocode_e            code;
      logic              usb_err;
      logic              proc_err;
      tok_t              tok;
   } rsp_t;

endpackage

// File: rtl/xdu_token_dec.sv
module xdu_token_dec
   import xdu_pkg::*;
(
   input  logic [31:0] token,
   output tok_t        tok
);
   logic [LEN_W-1:0] len_m1;

   assign len_m1     = token[31:21];
   assign tok.pid    = token[7:0];
   assign tok.dev    = token[14:8];
   assign tok.ep     = token[18:15];
   assign tok.maxlen = len_m1 + LEN_W'(1);
endmodule

// File: rtl/xdu_retry.sv
module xdu_retry
   import xdu_pkg::*;
(
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic [CTRL_W-1:0] ctrl_out,
   output logic              exhausted
);
   logic [1:0] cnt;
   logic [1:0] cnt_nxt;

   assign cnt = ctrl_in[B_ERR_LO +: 2];

   always_comb begin
      ctrl_out        = ctrl_in;
      ctrl_out[B_TMO] = 1'b1;
      exhausted       = 1'b0;
      cnt_nxt         = cnt;
      if (cnt != 2'd0) begin
         cnt_nxt = cnt - 2'd1;
         if (cnt_nxt == 2'd0) begin
            ctrl_out[B_ACT] = 1'b0;
            exhausted       = 1'b1;
         end
      end
      ctrl_out[B_ERR_LO +: 2] = cnt_nxt;
   end
endmodule

// File: rtl/xdu_outcome.sv
module xdu_outcome
   import xdu_pkg::*;
#(
   parameter int         CNT_W     = 12,
   parameter logic [7:0] PID_OUT   = 8'hE1,
   parameter logic [7:0] PID_IN    = 8'h69,
   parameter logic [7:0] PID_SETUP = 8'h2D
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  tok_t              tok,
   input  logic [2:0]        kind,
   input  logic [CNT_W-1:0]  count,
   output rsp_t              rsp
);
   logic              is_in, is_setup, pid_ok, overrun, short_pkt;
   logic [LEN_W-1:0]  xfer_len;
   logic [CTRL_W-1:0] base, retry_in, retry_out;
   logic              retry_exh;
   rkind_e            rk;

   assign rk       = rkind_e'(kind);
   assign is_in    = (tok.pid == PID_IN);
   assign is_setup = (tok.pid == PID_SETUP);
   assign pid_ok   = is_in || is_setup || (tok.pid == PID_OUT);
   assign overrun  = is_in && (rk == RK_DATA) && (count > CNT_W'(tok.maxlen));
   assign xfer_len = is_in ? count[LEN_W-1:0] : tok.maxlen;
   assign short_pkt = is_in && ctrl[B_SPD] && (xfer_len < tok.maxlen);

   always_comb begin
      base = ctrl;
      if (ctrl[B_ISO]) base[B_ACT] = 1'b0;
      retry_in = base;
      if (rk == RK_NAK) retry_in[B_NAK] = 1'b1;
   end

   xdu_retry u_retry (
      .ctrl_in   (retry_in),
      .ctrl_out  (retry_out),
      .exhausted (retry_exh)
   );

   always_comb begin
      rsp          = '0;
      rsp.tok      = tok;
      rsp.ctrl     = ctrl;
      rsp.code     = OC_HOLD;
      rsp.imask[0] = ctrl[B_IOC];
      if (!ctrl[B_ACT]) begin
         rsp.code = OC_HOLD;
      end else if (!pid_ok) begin
         rsp.proc_err = 1'b1;
         rsp.code     = OC_FATAL;
      end else if (rk == RK_DEFER) begin
         rsp.code = OC_DEFER;
      end else if (rk == RK_BABBLE || overrun) begin
         rsp.ctrl           = base;
         rsp.ctrl[B_BABBLE] = 1'b1;
         rsp.ctrl[B_STALL]  = 1'b1;
         rsp.ctrl[B_ACT]    = 1'b0;
         rsp.code           = OC_FATAL;
      end else begin
         unique case (rk)
            RK_DATA: begin
               rsp.ctrl               = base;
               rsp.ctrl[LEN_W-1:0]    = xfer_len - LEN_W'(1);
               rsp.ctrl[B_ACT]        = 1'b0;
               rsp.ctrl[B_NAK]        = 1'b0;
               if (short_pkt) begin
                  rsp.imask[1] = 1'b1;
                  rsp.code     = OC_HOLD;
               end else begin
                  rsp.code     = OC_ADV;
               end
            end
            RK_NAK: begin
               if (is_setup) begin
                  rsp.ctrl    = retry_out;
                  rsp.usb_err = retry_exh;
               end else begin
                  rsp.ctrl = retry_in;
               end
            end
            RK_STALL: begin
               rsp.ctrl          = base;
               rsp.ctrl[B_STALL] = 1'b1;
               rsp.ctrl[B_ACT]   = 1'b0;
            end
            default: begin
               rsp.ctrl    = retry_out;
               rsp.usb_err = retry_exh;
            end
         endcase
      end
   end
endmodule

// File: rtl/xfer_desc_update.sv
module xfer_desc_update
   import xdu_pkg::*;
#(
   parameter int         CNT_W     = 12,
   parameter bit         OUT_REG   = 1'b1,
   parameter logic [7:0] PID_OUT   = 8'hE1,
   parameter logic [7:0] PID_IN    = 8'h69,
   parameter logic [7:0] PID_SETUP = 8'h2D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [31:0]      req_ctrl,
   input  logic [31:0]      req_token,
   input  logic [2:0]       res_kind,
   input  logic [CNT_W-1:0] res_count,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [31:0]      rsp_ctrl,
   output logic [1:0]       rsp_imask,
   output logic [1:0]       rsp_code,
   output logic             rsp_usb_err,
   output logic             rsp_proc_err,
   output logic [7:0]       rsp_pid,
   output logic [6:0]       rsp_dev,
   output logic [3:0]       rsp_ep,
   output logic [10:0]      rsp_maxlen
);
   if (CNT_W <= LEN_W) begin : g_bad_cnt
      $error("CNT_W must exceed the length field width");
   end
   if (PID_OUT == PID_IN || PID_IN == PID_SETUP || PID_OUT == PID_SETUP) begin : g_bad_pid
      $error("packet identifiers must differ");
   end

   tok_t tok;
   rsp_t rsp_nxt, rsp_cur;

   xdu_token_dec u_dec (
      .token (req_token),
      .tok   (tok)
   );

   xdu_outcome #(
      .CNT_W     (CNT_W),
      .PID_OUT   (PID_OUT),
      .PID_IN    (PID_IN),
      .PID_SETUP (PID_SETUP)
   ) u_out (
      .ctrl  (req_ctrl),
      .tok   (tok),
      .kind  (res_kind),
      .count (res_count),
      .rsp   (rsp_nxt)
   );

   if (OUT_REG) begin : g_reg
      logic vld_q;
      rsp_t rsp_q;

      assign req_ready = !vld_q || rsp_ready;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
         end else if (req_ready) begin
            vld_q <= req_valid;
            if (req_valid) rsp_q <= rsp_nxt;
         end
      end

      assign rsp_valid = vld_q;
      assign rsp_cur   = rsp_q;
   end else begin : g_thru
      assign req_ready = rsp_ready;
      assign rsp_valid = req_valid;
      assign rsp_cur   = rsp_nxt;
   end

   assign rsp_ctrl     = rsp_cur.ctrl;
   assign rsp_imask    = rsp_cur.imask;
   assign rsp_code     = rsp_cur.code;
   assign rsp_usb_err  = rsp_cur.usb_err;
   assign rsp_proc_err = rsp_cur.proc_err;
   assign rsp_pid      = rsp_cur.tok.pid;
   assign rsp_dev      = rsp_cur.tok.dev;
   assign rsp_ep       = rsp_cur.tok.ep;
   assign rsp_maxlen   = rsp_cur.tok.maxlen;
endmodule

// File: rtl/xfer_desc_update_chk.sv
module xfer_desc_update_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic [31:0] rsp_ctrl,
   input logic [1:0]  rsp_imask,
   input logic [1:0]  rsp_code,
   input logic        rsp_usb_err,
   input logic        rsp_proc_err
);
   AST_PROC_ERR_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_proc_err) |-> (rsp_code == 2'd2)) else $error("proc err not fatal"); // R4

   AST_USB_ERR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_usb_err) |-> (!rsp_ctrl[23] && rsp_ctrl[18] && rsp_ctrl[28:27] == 2'd0)) else $error("usb err shape"); // R8

   AST_ADVANCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd0) |-> (!rsp_ctrl[23] && !rsp_ctrl[19])) else $error("advance left active"); // R6

   AST_SHORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_imask[1]) |-> (rsp_code == 2'd1 && rsp_ctrl[29])) else $error("short packet code"); // R7

   AST_DEFER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd3) |-> (!rsp_usb_err && !rsp_proc_err && rsp_ctrl[23])) else $error("defer flags"); // R12

   AST_FATAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd2 && !rsp_proc_err) |-> (!rsp_ctrl[23] && rsp_ctrl[22] && rsp_ctrl[20])) else $error("babble shape"); // R5

   if (OUT_REG) begin : g_hold
      AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ctrl) && $stable(rsp_code) && $stable(rsp_imask))) else $error("response moved"); // R13

      AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !rsp_ready) |-> !req_ready) else $error("ready while held"); // R13
   end
endmodule

bind xfer_desc_update xfer_desc_update_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .rsp_ready    (rsp_ready),
   .rsp_ctrl     (rsp_ctrl),
   .rsp_imask    (rsp_imask),
   .rsp_code     (rsp_code),
   .rsp_usb_err  (rsp_usb_err),
   .rsp_proc_err (rsp_proc_err)
);

// File: tb/xfer_desc_update_test.sv
module xfer_desc_update_test;

   typedef struct packed {
      logic [31:0] ctrl;
      logic [31:0] tok;
      logic [2:0]  kind;
      logic [11:0] cnt;
      logic [31:0] ectrl;
      logic [1:0]  emask;
      logic [1:0]  ecode;
      logic        eue;
      logic        epe;
   } vec_t;

   localparam logic [31:0] T_IN   = 32'h00E1_0569;
   localparam logic [31:0] T_OUT  = 32'h00E1_05E1;
   localparam logic [31:0] T_SET  = 32'h00E1_052D;
   localparam logic [31:0] T_BAD  = 32'h00E1_0555;
   localparam logic [31:0] T_WRAP = 32'hFFE1_05E1;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{32'h1880_07FF, T_IN,  3'd0, 12'd8,  32'h1800_0007, 2'b00, 2'd0, 1'b0, 1'b0}, // R6 full IN
      '{32'h3980_0000, T_IN,  3'd0, 12'd3,  32'h3900_0002, 2'b11, 2'd1, 1'b0, 1'b0}, // R7 short, R2
      '{32'h1880_0000, T_IN,  3'd0, 12'd3,  32'h1800_0002, 2'b00, 2'd0, 1'b0, 1'b0}, // R6 short no detect
      '{32'h2080_0000, T_IN,  3'd0, 12'd0,  32'h2000_07FF, 2'b10, 2'd1, 1'b0, 1'b0}, // R7 zero bytes
      '{32'h1880_0000, T_IN,  3'd0, 12'd12, 32'h1850_0000, 2'b00, 2'd2, 1'b0, 1'b0}, // R5 overrun
      '{32'h1888_0000, T_OUT, 3'd0, 12'd0,  32'h1800_0007, 2'b00, 2'd0, 1'b0, 1'b0}, // R6 OUT clears NAK
      '{32'h1880_0000, T_OUT, 3'd1, 12'd0,  32'h1888_0000, 2'b00, 2'd1, 1'b0, 1'b0}, // R9 NAK
      '{32'h1880_0000, T_SET, 3'd1, 12'd0,  32'h108C_0000, 2'b00, 2'd1, 1'b0, 1'b0}, // R9 SETUP NAK retries
      '{32'h0880_0000, T_IN,  3'd3, 12'd0,  32'h0004_0000, 2'b00, 2'd1, 1'b1, 1'b0}, // R8 last retry
      '{32'h0080_0000, T_IN,  3'd6, 12'd0,  32'h0084_0000, 2'b00, 2'd1, 1'b0, 1'b0}, // R8 counter zero
      '{32'h1880_0000, T_IN,  3'd2, 12'd0,  32'h1840_0000, 2'b00, 2'd1, 1'b0, 1'b0}, // R10 stall
      '{32'h1980_0000, T_IN,  3'd5, 12'd0,  32'h1980_0000, 2'b01, 2'd3, 1'b0, 1'b0}, // R12 deferred
      '{32'h0100_0005, T_IN,  3'd0, 12'd8,  32'h0100_0005, 2'b01, 2'd1, 1'b0, 1'b0}, // R3 inactive
      '{32'h0180_0000, T_BAD, 3'd0, 12'd0,  32'h0180_0000, 2'b01, 2'd2, 1'b0, 1'b1}, // R4 bad PID
      '{32'h0280_0000, T_IN,  3'd1, 12'd0,  32'h0208_0000, 2'b00, 2'd1, 1'b0, 1'b0}, // R11 iso NAK
      '{32'h1880_0000, T_OUT, 3'd4, 12'd0,  32'h1850_0000, 2'b00, 2'd2, 1'b0, 1'b0}, // R5 babble result
      '{32'h1880_0000, T_WRAP,3'd0, 12'd0,  32'h1800_07FF, 2'b00, 2'd0, 1'b0, 1'b0}  // R1 max wraps, R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_ctrl = '0;
   logic [31:0] req_token = '0;
   logic [2:0]  res_kind = '0;
   logic [11:0] res_count = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_ctrl;
   logic [1:0]  rsp_imask;
   logic [1:0]  rsp_code;
   logic        rsp_usb_err;
   logic        rsp_proc_err;
   logic [7:0]  rsp_pid;
   logic [6:0]  rsp_dev;
   logic [3:0]  rsp_ep;
   logic [10:0] rsp_maxlen;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   xfer_desc_update uut (
      .clk, .rst_n, .req_valid, .req_ready, .req_ctrl, .req_token,
      .res_kind, .res_count, .rsp_valid, .rsp_ready, .rsp_ctrl,
      .rsp_imask, .rsp_code, .rsp_usb_err, .rsp_proc_err,
      .rsp_pid, .rsp_dev, .rsp_ep, .rsp_maxlen
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] pack_out();
      return {16'h0, rsp_ctrl, rsp_imask, rsp_code, rsp_usb_err, rsp_proc_err, 10'h0};
   endfunction

   function automatic logic [63:0] pack_exp(vec_t v);
      return {16'h0, v.ectrl, v.emask, v.ecode, v.eue, v.epe, 10'h0};
   endfunction

   function automatic logic [29:0] dec_exp(logic [31:0] t);
      logic [10:0] m;
      m = t[31:21] + 11'd1;
      return {t[7:0], t[14:8], t[18:15], m};
   endfunction

   task automatic drive(vec_t v);
      req_ctrl  = v.ctrl;
      req_token = v.tok;
      res_kind  = v.kind;
      res_count = v.cnt;
      req_valid = 1'b1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      check(rsp_valid == 1'b0 && req_ready == 1'b1, "R13 reset state", {rsp_valid, req_ready}, 2'b01);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 and R1 decode
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         rsp_ready = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check(rsp_valid && pack_out() == pack_exp(VECS[i]),
               $sformatf("vector %0d outcome", i), pack_out(), pack_exp(VECS[i]));
         check({rsp_pid, rsp_dev, rsp_ep, rsp_maxlen} == dec_exp(VECS[i].tok),
               $sformatf("R1 decode vector %0d", i),
               {rsp_pid, rsp_dev, rsp_ep, rsp_maxlen}, dec_exp(VECS[i].tok));
         @(negedge clk);
      end

      // R1 wrap: all-ones length field gives a maximum of 0
      drive(VECS[16]);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_maxlen == 11'd0, "R1 max wrap", rsp_maxlen, 0);
      @(negedge clk);

      // R13 backpressure: hold response, block requests
      drive(VECS[6]);
      rsp_ready = 1'b0;
      @(negedge clk);
      check(rsp_valid && !req_ready, "R13 ready low while held", {rsp_valid, req_ready}, 2'b10);
      drive(VECS[10]);
      @(negedge clk);
      check(rsp_valid && rsp_ctrl == VECS[6].ectrl, "R13 held response", rsp_ctrl, VECS[6].ectrl);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_ctrl == VECS[10].ectrl && rsp_code == 2'd1,
            "R13 next after release R10", rsp_ctrl, VECS[10].ectrl);
      @(negedge clk);
      check(!rsp_valid, "R13 drained", rsp_valid, 0);

      // R8 counter 3 on timeout keeps active, decrements to 2
      drive('{32'h1880_0000, T_OUT, 3'd7, 12'd0, 32'h1084_0000, 2'b00, 2'd1, 1'b0, 1'b0});
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_ctrl == 32'h1084_0000 && !rsp_usb_err, "R8 counter three", rsp_ctrl, 32'h1084_0000);
      @(negedge clk);

      // R11 iso with stall still R10 shape; iso on retry leaves active clear
      drive('{32'h1A80_0000, T_IN, 3'd6, 12'd0, 32'h1204_0000, 2'b00, 2'd1, 1'b0, 1'b0});
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_ctrl == 32'h1204_0000, "R11 iso retry", rsp_ctrl, 32'h1204_0000);
      @(negedge clk);

      // R2 IOC on fatal babble
      drive('{32'h0180_0000, T_IN, 3'd0, 12'd9, 32'h0150_0000, 2'b01, 2'd2, 1'b0, 1'b0});
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_imask == 2'b01 && rsp_code == 2'd2 && rsp_ctrl == 32'h0150_0000,
            "R2 IOC on babble R5", {rsp_imask, rsp_code, rsp_ctrl}, {2'b01, 2'd2, 32'h0150_0000});
      @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule